// File: doc/BRIEF.md
# Staged Ratio Clock-Enable Divider Bank

This block derives nine clock-enable streams from one source clock. Each stream pulses high for one source cycle once every N cycles. N comes from a 4-bit ratio code looked up in a fixed, non-uniform divisor table that includes the odd ratios 3 and 7. Software programs the codes through two 32-bit control words. A write only stages the new codes. Software then sets a commit bit, and the staged set goes live on every channel at once.

A commit is carried out by a small state machine with three states. ST_IDLE is the quiet state. A write that sets the commit bit moves it to ST_DRAIN. In ST_DRAIN, each channel finishes its current period and then parks silently. Once every channel is parked, the machine moves to ST_APPLY. ST_APPLY loads the staged codes into all channels, restarts every counter from zero in the same cycle, and returns to ST_IDLE. Channel 6 also has a bypass bit. With bypass committed, that channel's enable is high on every source cycle. Each channel only accepts codes that its own permission mask allows.

Top module: `ratio_kick_divider`

## Requirements
- R1: Code k selects divisor D(k): 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→7. A running channel raises its enable for exactly one cycle out of every D(k) cycles.
- R2: Control word 0 (rd_sel/wr_sel = 0) holds the codes of channels 0..5 at bit offsets 20, 16, 12, 8, 4 and 0. Word 1 holds channel 6 at bit 24, channel 7 at bit 12, channel 8 at bit 4, the bypass bit at bit 28 and the commit bit at bit 31. A read returns the staged codes. All other bits read 0.
- R3: Bit k of a channel's mask permits code k. The masks are 0xdff, 0xd7f, 0x1dff, 0xdff, 0x1dff, 0x1dff, 0x97f, 0xdff and 0xdff for channels 0..8, and codes 13..15 are never permitted. A write carrying a forbidden code leaves that channel's staged code unchanged and sets err_flag. err_flag stays set until reset.
- R4: Staged codes and the staged bypass bit do not change any output until a commit completes.
- R5: The commit bit reads 1 from the cycle after it is written until the new ratios are live, and then returns to 0 by itself. Each channel parks at its own period end, and all channels restart together. A channel never pulses on two consecutive cycles unless it is bypassed.
- R6: Any write that arrives while the commit bit reads 1 is ignored entirely.
- R7: When bypass is committed, channel 6 raises its enable on every cycle.
- R8: After reset, all codes are 0 (divide by 2), bypass is 0, the commit bit is 0 and err_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Selects the control word written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Selects the control word read |
| rd_data | output | 32 | Read data (combinational) |
| err_flag | output | 1 | Sticky flag for forbidden codes |
| ce_out | output | 9 | One enable per channel |

## Verification
A register write and a commit in progress can land in the same cycle. The write must then be refused, while a write in the first cycle after the commit bit reads 0 must be accepted. The bench provokes this by issuing a second write on the cycle right after a commit write. It judges the result by reading both words back after the commit bit clears and by measuring the periods the channels actually produce. A runt monitor watches every non-bypassed channel across all commits for back-to-back pulses.

// File: rtl/ratio_kick_pkg.sv
package ratio_kick_pkg;
    localparam int NUM_CH = 9;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 6;
    localparam int WORD_W = 32;
    localparam int KICK_BIT = 31;
    localparam int BYP_BIT  = 28;
    localparam int BYP_CH   = 6;

    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_APPLY} kick_state_t;

    function automatic logic [CNT_W-1:0] code_to_div(input logic [CODE_W-1:0] c);
        case (c)
            4'd0:  return 6'd2;
            4'd1:  return 6'd3;
            4'd2:  return 6'd4;
            4'd3:  return 6'd6;
            4'd4:  return 6'd8;
            4'd5:  return 6'd12;
            4'd6:  return 6'd16;
            4'd7:  return 6'd18;
            4'd8:  return 6'd24;
            4'd10: return 6'd36;
            4'd11: return 6'd48;
            4'd12: return 6'd7;
            default: return 6'd2;
        endcase
    endfunction

    function automatic logic [15:0] chan_mask(input int ch);
        case (ch)
            1: return 16'h0d7f;
            2, 4, 5: return 16'h1dff;
            6: return 16'h097f;
            default: return 16'h0dff;
        endcase
    endfunction

    function automatic int field_lsb(input int ch);
        if (ch < 6) return 20 - 4 * ch;
        if (ch == 6) return 24;
        if (ch == 7) return 12;
        return 4;
    endfunction

    function automatic logic field_word(input int ch);
        return (ch >= 6);
    endfunction
endpackage

// File: rtl/ratio_stage.sv
module ratio_stage
    import ratio_kick_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           wr_sel,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic                           busy,
    output logic [NUM_CH-1:0][CODE_W-1:0]  codes_q,
    output logic                           byp_q,
    output logic                           kick_req,
    output logic                           err_q
);
    logic accept;
    assign accept   = wr_en && !busy;
    assign kick_req = accept && wr_sel && wr_data[KICK_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes_q <= '0;
            byp_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (field_word(ch) == wr_sel) begin
                    if (chan_mask(ch)[wr_data[field_lsb(ch) +: CODE_W]])
                        codes_q[ch] <= wr_data[field_lsb(ch) +: CODE_W];
                    else
                        err_q <= 1'b1;
                end
            end
            if (wr_sel) byp_q <= wr_data[BYP_BIT];
        end
    end

    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(codes_q) && $stable(byp_q)));
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_legal
        a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
            chan_mask(g)[codes_q[g]]);
    end
endmodule

// File: rtl/ratio_kick_fsm.sv
module ratio_kick_fsm
    import ratio_kick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    input  logic all_parked,
    output logic drain,
    output logic apply,
    output logic busy
);
    kick_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (kick_req)   state_d = ST_DRAIN;
            ST_DRAIN: if (all_parked) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drain = (state_q == ST_DRAIN);
        apply = (state_q == ST_APPLY);
        busy  = (state_q != ST_IDLE);
    end

    a_r5_apply_needs_park: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> all_parked);
    a_r5_kick_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !busy);
endmodule

// File: rtl/ratio_chan.sv
module ratio_chan
    import ratio_kick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drain,
    input  logic              apply,
    input  logic [CODE_W-1:0] new_code,
    input  logic              new_byp,
    output logic              ce,
    output logic              parked
);
    logic [CODE_W-1:0] act_code;
    logic              act_byp;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic              wrap;

    assign last = code_to_div(act_code) - 6'd1;
    assign wrap = act_byp || (cnt == last);
    assign ce   = !parked && !apply && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code <= '0;
            act_byp  <= 1'b0;
            cnt      <= '0;
            parked   <= 1'b0;
        end else if (apply) begin
            act_code <= new_code;
            act_byp  <= new_byp;
            cnt      <= '0;
            parked   <= 1'b0;
        end else if (!parked) begin
            if (wrap) begin
                cnt <= '0;
                if (drain) parked <= 1'b1;
            end else begin
                cnt <= cnt + 6'd1;
            end
        end
    end

    a_r4_change_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> $past(apply));
    a_r5_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !act_byp) |=> !ce);
endmodule

// File: rtl/ratio_kick_divider.sv
module ratio_kick_divider
    import ratio_kick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              rd_sel,
    output logic [31:0]       rd_data,
    output logic              err_flag,
    output logic [8:0]        ce_out
);
    logic [NUM_CH-1:0][CODE_W-1:0] codes;
    logic                          byp;
    logic                          kick_req;
    logic                          drain, apply, busy;
    logic [NUM_CH-1:0]             parked;

    ratio_stage u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .codes_q(codes), .byp_q(byp),
        .kick_req(kick_req), .err_q(err_flag)
    );

    ratio_kick_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req),
        .all_parked(&parked), .drain(drain), .apply(apply), .busy(busy)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic byp_in;
        if (g == BYP_CH) begin : g_byp
            assign byp_in = byp;
        end else begin : g_nobyp
            assign byp_in = 1'b0;
        end
        ratio_chan u_chan (
            .clk(clk), .rst_n(rst_n), .drain(drain), .apply(apply),
            .new_code(codes[g]), .new_byp(byp_in),
            .ce(ce_out[g]), .parked(parked[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (field_word(ch) == rd_sel)
                rd_data[field_lsb(ch) +: CODE_W] = codes[ch];
        end
        if (rd_sel) begin
            rd_data[BYP_BIT]  = byp;
            rd_data[KICK_BIT] = busy;
        end
    end

    a_r4_quiet_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !kick_req) |=> !apply);
endmodule

// File: tb/ratio_kick_divider_bench.sv
module ratio_kick_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        err_flag;
    logic [8:0]  ce_out;

    int total = 0;
    int bad = 0;
    int runts = 0;
    logic [8:0] prev_ce = '0;

    always #2 clk = ~clk;

    ratio_kick_divider u_ratio_kick_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .err_flag(err_flag), .ce_out(ce_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 9; c++)
                if (c != 6 && ce_out[c] && prev_ce[c]) runts++;
            prev_ce <= ce_out;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic period(input int ch, output int p);
        int t = 0;
        while (!ce_out[ch] && t < 300) begin @(negedge clk); t++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!ce_out[ch] && p < 300);
    endtask

    task automatic wait_commit();
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(1'b1, v);
            if (!v[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v; int p;
        rd(1'b0, v); check("R8 word0", v, 0);
        rd(1'b1, v); check("R8 word1", v, 0);
        check("R8 err", err_flag, 0);
        period(0, p); check("R8 ch0 div2", p, 2);
    endtask

    task automatic t_stage_and_commit();
        logic [31:0] v; int p;
        int expd [9] = '{3, 4, 7, 24, 48, 18, 6, 8, 12};
        wr(1'b0, 32'h0012C8B7);
        rd(1'b0, v); check("R2 word0 readback", v, 32'h0012C8B7);
        period(0, p); check("R4 ch0 unchanged before commit", p, 2);
        period(3, p); check("R4 ch3 unchanged before commit", p, 2);
        wr(1'b1, 32'h83004050);
        rd(1'b1, v); check("R5 commit bit pending", v[31], 1);
        wait_commit();
        rd(1'b1, v); check("R5 commit cleared, R2 word1", v, 32'h03004050);
        for (int c = 0; c < 9; c++) begin
            period(c, p);
            check($sformatf("R1 ch%0d period", c), p, expd[c]);
        end
    endtask

    task automatic t_busy();
        logic [31:0] v; int p;
        wr(1'b1, 32'h83006050);
        wr(1'b0, 32'h0002C8B7);
        wait_commit();
        rd(1'b0, v); check("R6 word0 write ignored", v, 32'h0012C8B7);
        rd(1'b1, v); check("R6 word1 after commit", v, 32'h03006050);
        period(0, p); check("R6 ch0 keeps div3", p, 3);
        period(7, p); check("R1 ch7 div16", p, 16);
        wr(1'b0, 32'h0002C8B7);
        rd(1'b0, v); check("R6 write accepted once idle", v, 32'h0002C8B7);
        wr(1'b0, 32'h0012C8B7);
    endtask

    task automatic t_forbidden();
        logic [31:0] v;
        check("R3 err clear before", err_flag, 0);
        wr(1'b0, 32'h0097C8B7);
        rd(1'b0, v); check("R3 forbidden codes kept old", v, 32'h0012C8B7);
        check("R3 err set", err_flag, 1);
        wr(1'b0, 32'h0012C8B7);
        check("R3 err sticky", err_flag, 1);
    endtask

    task automatic t_bypass();
        logic [31:0] v; int p;
        wr(1'b1, 32'h13006050);
        period(6, p); check("R4 bypass staged only", p, 6);
        wr(1'b1, 32'h93006050);
        wait_commit();
        rd(1'b1, v); check("R7 word1", v, 32'h13006050);
        period(6, p); check("R7 ch6 bypass", p, 1);
        period(8, p); check("R1 ch8 div12", p, 12);
        check("R5 no runt pulses", runts, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage_and_commit();
        t_busy();
        t_forbidden();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule